// File: doc/BRIEF.md
# Sleep Mode Entry Controller

This block decides when a processor core stops and when it starts again. Software sets two bits in an 8-bit control register: an enable bit and a mode bit. When the core's decoder signals that it has executed a sleep instruction, the controller checks the enable bit. If the bit is set, the core halts. If it is clear, the instruction does nothing. The mode bit picks between two low-power states. In the light state only the core clock is stopped. In the deep state every gated clock is stopped.

Any pending interrupt request that is already enabled wakes the core from either state. On wake the controller drops the halt signal and gives a one-cycle wake pulse. The program counter was already past the sleep instruction when the core halted, so the core carries on with the next instruction. A wake request that arrives in the same cycle as the sleep strobe cancels the entry, so the wakeup cannot be lost.

The reset input clears asynchronously. Its release is synchronised to the clock inside the block, so the block leaves reset two clock edges after the input rises.

Top module: `slp_ctrl_top`

## Requirements
- R1: During reset and after it, the register reads 0x00 and halt_o, core_clk_gate_o, periph_clk_gate_o and wake_o are all 0.
- R2: A write stores bit 5 (sleep enable) and bit 4 (mode select: 0 = light, 1 = deep). A read returns those two bits in the same positions, and every other bit reads 0.
- R3: A sleep strobe seen while the enable bit is 0 has no effect. halt_o stays 0 and both gate outputs stay 0.
- R4: A sleep strobe with the enable bit 1 and the mode bit 0 sets halt_o and core_clk_gate_o at the next clock edge. periph_clk_gate_o stays 0.
- R5: A sleep strobe with the enable bit 1 and the mode bit 1 sets halt_o, core_clk_gate_o and periph_clk_gate_o at the next clock edge.
- R6: While halted, any bit set in irq_req_i clears halt_o and both gate outputs at the next clock edge. wake_o is 1 for exactly that one cycle.
- R7: A wake request in the same cycle as a sleep strobe blocks entry. halt_o stays 0 and no wake pulse is produced.
- R8: While halted with no wake request, further sleep strobes and register writes do not change the current state or its gate outputs.
- R9: A strobe in the same cycle as a register write uses the enable and mode values held before that write.
- R10: wake_o is 1 only in the cycle right after a cycle with halt_o at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register read data |
| sleep_exec_i | input | 1 | One-cycle strobe: a sleep instruction has executed |
| irq_req_i | input | NIRQ | Pending and enabled interrupt requests |
| halt_o | output | 1 | Core halted |
| core_clk_gate_o | output | 1 | 1 = core clock stopped |
| periph_clk_gate_o | output | 1 | 1 = peripheral clocks stopped |
| wake_o | output | 1 | One-cycle wake pulse |

## Verification
The hardest case to reach is a race between sleep entry and wake. In one variant a wake request and a sleep strobe land in the same cycle. In another, a register write and a sleep strobe land in the same cycle. Random stimulus rarely lines these up. Directed steps therefore drive each pair together on purpose. Long random runs then mix strobes, writes and interrupt requests at rates chosen so that both sleep states are entered and left many times, and each cycle is compared against a bench model.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_LIGHT = 2'd1,
    ST_DEEP  = 2'd2
  } slp_state_e;
endpackage

// File: rtl/slp_rst_sync.sv
module slp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/slp_ctl_reg.sv
module slp_ctl_reg #(
  parameter int REG_W  = 8,
  parameter int SE_POS = 5,
  parameter int SM_POS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             se_o,
  output logic             sm_o
);
  logic se_q, se_d;
  logic sm_q, sm_d;
  logic unused_wbits;

  assign unused_wbits = ^wdata_i;

  always_comb begin
    se_d = se_q;
    sm_d = sm_q;
    if (we_i) begin
      se_d = wdata_i[SE_POS];
      sm_d = wdata_i[SM_POS];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      se_q <= 1'b0;
      sm_q <= 1'b0;
    end else begin
      se_q <= se_d;
      sm_q <= sm_d;
    end
  end

  always_comb begin
    rdata_o         = '0;
    rdata_o[SE_POS] = se_q;
    rdata_o[SM_POS] = sm_q;
  end

  assign se_o = se_q;
  assign sm_o = sm_q;
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import slp_pkg::*;
#(
  parameter int NIRQ = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            se_i,
  input  logic            sm_i,
  input  logic            strobe_i,
  input  logic [NIRQ-1:0] irq_req_i,
  output slp_state_e      state_o,
  output logic            wake_o
);
  slp_state_e state_q, state_d;
  logic       wake_q, wake_d;
  logic       wake_req;

  assign wake_req = |irq_req_i;

  always_comb begin
    state_d = state_q;
    wake_d  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (strobe_i && se_i && !wake_req) begin
          state_d = sm_i ? ST_DEEP : ST_LIGHT;
        end
      end
      ST_LIGHT, ST_DEEP: begin
        if (wake_req) begin
          state_d = ST_RUN;
          wake_d  = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
    end
  end

  assign state_o = state_q;
  assign wake_o  = wake_q;
endmodule

// File: rtl/slp_gate_dec.sv
module slp_gate_dec
  import slp_pkg::*;
(
  input  slp_state_e state_i,
  output logic       halt_o,
  output logic       core_gate_o,
  output logic       periph_gate_o
);
  always_comb begin
    halt_o        = 1'b0;
    core_gate_o   = 1'b0;
    periph_gate_o = 1'b0;
    unique case (state_i)
      ST_LIGHT: begin
        halt_o      = 1'b1;
        core_gate_o = 1'b1;
      end
      ST_DEEP: begin
        halt_o        = 1'b1;
        core_gate_o   = 1'b1;
        periph_gate_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/slp_ctrl_top.sv
module slp_ctrl_top
  import slp_pkg::*;
#(
  parameter int NIRQ   = 4,
  parameter int REG_W  = 8,
  parameter int SE_POS = 5,
  parameter int SM_POS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [REG_W-1:0] ctl_wdata_i,
  output logic [REG_W-1:0] ctl_rdata_o,
  input  logic             sleep_exec_i,
  input  logic [NIRQ-1:0]  irq_req_i,
  output logic             halt_o,
  output logic             core_clk_gate_o,
  output logic             periph_clk_gate_o,
  output logic             wake_o
);
  logic       rst_sync_n;
  logic       se, sm;
  slp_state_e state;

  slp_rst_sync #(.STAGES(2)) rst_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  slp_ctl_reg #(.REG_W(REG_W), .SE_POS(SE_POS), .SM_POS(SM_POS)) reg_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .we_i    (ctl_we_i),
    .wdata_i (ctl_wdata_i),
    .rdata_o (ctl_rdata_o),
    .se_o    (se),
    .sm_o    (sm)
  );

  slp_fsm #(.NIRQ(NIRQ)) fsm_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .se_i      (se),
    .sm_i      (sm),
    .strobe_i  (sleep_exec_i),
    .irq_req_i (irq_req_i),
    .state_o   (state),
    .wake_o    (wake_o)
  );

  slp_gate_dec dec_i (
    .state_i       (state),
    .halt_o        (halt_o),
    .core_gate_o   (core_clk_gate_o),
    .periph_gate_o (periph_clk_gate_o)
  );
endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk #(
  parameter int NIRQ = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            se_i,
  input logic            sleep_exec_i,
  input logic [NIRQ-1:0] irq_req_i,
  input logic            halt_o,
  input logic            core_clk_gate_o,
  input logic            periph_clk_gate_o,
  input logic            wake_o
);
  // R3
  no_entry_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_exec_i && !se_i && !halt_o) |=> !halt_o);

  // R5
  deep_gates_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    periph_clk_gate_o |-> (halt_o && core_clk_gate_o));

  // R6
  wake_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  // R7
  race_blocks_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && (|irq_req_i)) |=> !halt_o);

  // R8
  asleep_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !(|irq_req_i)) |=> (halt_o && $stable(periph_clk_gate_o)));

  // R10
  wake_after_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (!halt_o && $past(halt_o)));
endmodule

bind slp_ctrl_top slp_ctrl_chk #(.NIRQ(NIRQ)) chk_i (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .se_i              (ctl_rdata_o[SE_POS]),
  .sleep_exec_i      (sleep_exec_i),
  .irq_req_i         (irq_req_i),
  .halt_o            (halt_o),
  .core_clk_gate_o   (core_clk_gate_o),
  .periph_clk_gate_o (periph_clk_gate_o),
  .wake_o            (wake_o)
);

// File: tb/slp_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module slp_ctrl_top_tb_top;
  localparam int NIRQ = 4;

  logic            clk;
  logic            rst_n;
  logic            we;
  logic [7:0]      wdata;
  logic [7:0]      rdata;
  logic            strobe;
  logic [NIRQ-1:0] irq;
  logic            halt, cgate, pgate, wake;

  int checks;
  int errors;
  bit done;

  // model state: 0 run, 1 light, 2 deep
  int m_st;
  bit m_se, m_sm, m_wake;

  slp_ctrl_top #(.NIRQ(NIRQ)) dut_i (
    .clk_i             (clk),
    .rst_ni            (rst_n),
    .ctl_we_i          (we),
    .ctl_wdata_i       (wdata),
    .ctl_rdata_o       (rdata),
    .sleep_exec_i      (strobe),
    .irq_req_i         (irq),
    .halt_o            (halt),
    .core_clk_gate_o   (cgate),
    .periph_clk_gate_o (pgate),
    .wake_o            (wake)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int next_st(int st, bit se, bit sm, bit stb, bit req);
    if (st == 0) return (stb && se && !req) ? (sm ? 2 : 1) : 0;
    return req ? 0 : st;
  endfunction

  task automatic check(string tag);
    logic [3:0] got, exp;
    logic [7:0] exp_rd;
    got    = {halt, cgate, pgate, wake};
    exp    = {m_st != 0, m_st != 0, m_st == 2, m_wake};
    exp_rd = {2'b00, m_se, m_sm, 4'b0000};
    checks++;
    if (got !== exp || rdata !== exp_rd) begin
      errors++;
      $display("FAIL %s: halt/cg/pg/wake=%b rd=%h, expected %b rd=%h",
               tag, got, rdata, exp, exp_rd);
    end
  endtask

  task automatic step(string tag, bit w, logic [7:0] d, bit s, logic [NIRQ-1:0] q);
    we = w; wdata = d; strobe = s; irq = q;
    m_wake = (m_st != 0) && (q != 0);
    m_st   = next_st(m_st, m_se, m_sm, s, q != 0);
    if (w) begin m_se = d[5]; m_sm = d[4]; end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    checks = 0; errors = 0;
    m_st = 0; m_se = 0; m_sm = 0; m_wake = 0;
    rst_n = 1'b0; we = 0; wdata = '0; strobe = 0; irq = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset");

    step("R2 write all ones", 1, 8'hFF, 0, '0);
    step("R3 strobe disabled", 1, 8'h00, 0, '0);
    step("R3 no-op", 0, 8'h00, 1, '0);
    step("R4 set light", 1, 8'h20, 0, '0);
    step("R4 enter light", 0, 8'h00, 1, '0);
    step("R6 wake light", 0, 8'h00, 0, 4'b0100);
    step("R6 pulse ends", 0, 8'h00, 0, '0);
    step("R7 set deep", 1, 8'h30, 0, '0);
    step("R7 race", 0, 8'h00, 1, 4'b0001);
    step("R5 enter deep", 0, 8'h00, 1, '0);
    step("R8 strobe+write asleep", 1, 8'h20, 1, '0);
    step("R8 write disable asleep", 1, 8'h00, 0, '0);
    step("R6 wake deep", 0, 8'h00, 0, 4'b1000);
    step("R9 write with strobe", 1, 8'h20, 1, '0);
    step("R9 old sm used", 1, 8'h10, 1, '0);
    step("R6 wake", 0, 8'h00, 0, 4'b0010);

    for (int i = 0; i < 4000; i++) begin
      bit w, s;
      logic [7:0] d;
      logic [NIRQ-1:0] q;
      w = ($urandom_range(0, 9) == 0);
      d = 8'($urandom());
      s = ($urandom_range(0, 3) == 0);
      q = ($urandom_range(0, 7) == 0) ? NIRQ'($urandom()) : '0;
      step("R4 R5 R6 R10 random", w, d, s, q);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule